// File: doc/BRIEF.md
# Configurable Timeout Down-Counter

This block is a timeout down-counter meant to sit beside a bus controller's message queues. A register interface configures it with three fields: an enable, a two-bit mode select and a 16-bit preset period. The counter steps down by one on each pulse of an external bit-time tick. When a decrement brings it to zero it raises a sticky timeout flag and then stays at zero until it is re-armed.

There are two ways to re-arm the counter. In continuous mode, software reloads it with the preset period by writing to the counter register. In the three queue-controlled modes, the counter is held at the preset period for as long as the selected queue (transmit-event, receive 0 or receive 1) reports empty. Down-counting starts once the first element lands in that queue and its empty indication drops.

The configuration register is guarded by two controller-level lock inputs. A configuration write is accepted only while both of them are high. The queues, the protocol engine and interrupt routing are outside this block.

Top module: `timeout_ctr`

## Requirements
- R1: After reset the block is disabled, the mode is continuous (0), the preset period is 0xFFFF, `cnt_o` is 0xFFFF, `timeout_o` is 0, and a read of address 0 returns 0x0000FFFF.
- R2: A write to address 0 updates the configuration only when `lock_cce` and `lock_init` are both 1. Otherwise the configuration keeps its previous value. The configuration word holds the enable in bit 31, the mode in bits 17:16 and the preset period in bits 15:0.
- R3: While the enable is 0, `cnt_o` never changes. This covers ticks, counter writes and queue states.
- R4: In continuous mode with the enable set, any write to address 1, whatever its data, loads the preset period into the counter at that clock edge.
- R5: With the enable set and no load pending, the counter decrements by exactly one on each clock edge where `bit_tick` is 1 and the counter is non-zero. It is unchanged on edges where `bit_tick` is 0.
- R6: In a queue-controlled mode with the enable set, the counter is loaded with the preset period on every edge where the selected queue's empty bit is 1. Mode 1 selects `q_empty[0]` (transmit-event queue), mode 2 selects `q_empty[1]` (receive queue 0) and mode 3 selects `q_empty[2]` (receive queue 1).
- R7: In a queue-controlled mode, ticks decrement the counter once the selected queue is non-empty. The empty bits of unselected queues have no effect, and writes to address 1 are ignored.
- R8: A decrement that brings the counter to 0 sets `timeout_o`. Once the counter is at 0, further ticks leave it at 0 until it is re-armed by R4 or R6.
- R9: `timeout_o` is sticky. It is cleared only by a write to address 2 with data bit 0 equal to 1. If a set and a clear fall on the same edge, the set wins.
- R10: A read with `rd_en` high presents the addressed register on `rd_data` after the next clock edge, and `rd_data` holds between reads. Address 0 returns the configuration word, address 1 the counter in bits 15:0, address 2 the timeout flag in bit 0, and address 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 2 | Read address |
| rd_data | output | 32 | Registered read data |
| lock_cce | input | 1 | Configuration-change-enable lock bit from the controller |
| lock_init | input | 1 | Init lock bit from the controller |
| bit_tick | input | 1 | Bit-time tick; one decrement step per high cycle |
| q_empty | input | 3 | Empty flags: [0] transmit-event queue, [1] receive queue 0, [2] receive queue 1 |
| cnt_o | output | 16 | Current counter value |
| timeout_o | output | 1 | Sticky timeout flag |

## Verification
The bench builds the block with its default 16-bit counter and 32-bit data word. It uses short preset periods of one to nine ticks, so that reaching zero, holding at zero and the set-versus-clear collision all happen within a few dozen cycles. All four mode encodings are exercised while empty flags are toggled on both selected and unselected queues. Configuration writes are tried with the locks both closed and open, and this makes the write protection and the disabled-freeze behaviour observable through read-back and `cnt_o`.

// File: rtl/tmo_pkg.sv
package tmo_pkg;
  localparam int unsigned REG_ADDR_W = 2;
  localparam int unsigned MODE_W     = 2;
  localparam int unsigned NUM_QUEUES = 3;

  localparam logic [REG_ADDR_W-1:0] A_CFG  = 2'd0;
  localparam logic [REG_ADDR_W-1:0] A_CNT  = 2'd1;
  localparam logic [REG_ADDR_W-1:0] A_STAT = 2'd2;

  typedef enum logic [MODE_W-1:0] {
    MODE_CONT  = 2'd0,
    MODE_TXEVT = 2'd1,
    MODE_RXQ0  = 2'd2,
    MODE_RXQ1  = 2'd3
  } tmo_mode_e;
endpackage

// File: rtl/tmo_cfg_regs.sv
module tmo_cfg_regs
  import tmo_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [REG_ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic                  lock_cce,
  input  logic                  lock_init,
  output logic                  cfg_en,
  output tmo_mode_e             cfg_mode,
  output logic [CNT_W-1:0]      cfg_period,
  output logic                  reload_stb,
  output logic                  clear_stb
);
  localparam int unsigned MODE_LSB = CNT_W;
  localparam int unsigned EN_BIT   = DATA_W - 1;

  logic cfg_wr_ok;
  logic unused_wr;

  assign cfg_wr_ok  = wr_en && (wr_addr == A_CFG) && lock_cce && lock_init;
  assign reload_stb = wr_en && (wr_addr == A_CNT);
  assign clear_stb  = wr_en && (wr_addr == A_STAT) && wr_data[0];
  assign unused_wr  = ^wr_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_en     <= 1'b0;
      cfg_mode   <= MODE_CONT;
      cfg_period <= {CNT_W{1'b1}};
    end else if (cfg_wr_ok) begin
      cfg_en     <= wr_data[EN_BIT];
      cfg_mode   <= tmo_mode_e'(wr_data[MODE_LSB +: MODE_W]);
      cfg_period <= wr_data[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/tmo_qsel.sv
module tmo_qsel
  import tmo_pkg::*;
(
  input  tmo_mode_e               mode,
  input  logic [NUM_QUEUES-1:0]   q_empty,
  output logic                    queue_mode,
  output logic                    sel_empty
);
  logic [NUM_QUEUES-1:0] sel_hot;

  for (genvar qi = 0; qi < NUM_QUEUES; qi++) begin : g_sel
    assign sel_hot[qi] = (mode == tmo_mode_e'(qi + 1)) && q_empty[qi];
  end

  assign queue_mode = (mode != MODE_CONT);
  assign sel_empty  = |sel_hot;
endmodule

// File: rtl/tmo_core.sv
module tmo_core #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             queue_mode,
  input  logic             sel_empty,
  input  logic             reload_stb,
  input  logic             tick,
  input  logic             clear_stb,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] cnt,
  output logic             flag
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic load;
  logic step;
  logic expire;

  assign load   = en && (queue_mode ? sel_empty : reload_stb);
  assign step   = en && tick && (cnt != '0) && !load;
  assign expire = step && (cnt == ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= {CNT_W{1'b1}};
    end else if (load) begin
      cnt <= period;
    end else if (step) begin
      cnt <= cnt - ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
    end else if (expire) begin
      flag <= 1'b1;
    end else if (clear_stb) begin
      flag <= 1'b0;
    end
  end
endmodule

// File: rtl/timeout_ctr.sv
module timeout_ctr
  import tmo_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [REG_ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic                  rd_en,
  input  logic [REG_ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0]     rd_data,
  input  logic                  lock_cce,
  input  logic                  lock_init,
  input  logic                  bit_tick,
  input  logic [NUM_QUEUES-1:0] q_empty,
  output logic [CNT_W-1:0]      cnt_o,
  output logic                  timeout_o
);
  localparam int unsigned MODE_LSB = CNT_W;
  localparam int unsigned EN_BIT   = DATA_W - 1;

  logic             cfg_en;
  tmo_mode_e        cfg_mode;
  logic [CNT_W-1:0] cfg_period;
  logic             reload_stb;
  logic             clear_stb;
  logic             queue_mode;
  logic             sel_empty;
  logic [DATA_W-1:0] rd_next;

  tmo_cfg_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_cfg (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .lock_cce   (lock_cce),
    .lock_init  (lock_init),
    .cfg_en     (cfg_en),
    .cfg_mode   (cfg_mode),
    .cfg_period (cfg_period),
    .reload_stb (reload_stb),
    .clear_stb  (clear_stb)
  );

  tmo_qsel u_qsel (
    .mode       (cfg_mode),
    .q_empty    (q_empty),
    .queue_mode (queue_mode),
    .sel_empty  (sel_empty)
  );

  tmo_core #(.CNT_W(CNT_W)) u_core (
    .clk        (clk),
    .rst        (rst),
    .en         (cfg_en),
    .queue_mode (queue_mode),
    .sel_empty  (sel_empty),
    .reload_stb (reload_stb),
    .tick       (bit_tick),
    .clear_stb  (clear_stb),
    .period     (cfg_period),
    .cnt        (cnt_o),
    .flag       (timeout_o)
  );

  always_comb begin
    rd_next = '0;
    case (rd_addr)
      A_CFG: begin
        rd_next[CNT_W-1:0]            = cfg_period;
        rd_next[MODE_LSB +: MODE_W]   = cfg_mode;
        rd_next[EN_BIT]               = cfg_en;
      end
      A_CNT:   rd_next[CNT_W-1:0] = cnt_o;
      A_STAT:  rd_next[0]         = timeout_o;
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      rd_data <= rd_next;
    end
  end
endmodule

// File: rtl/timeout_ctr_chk.sv
module timeout_ctr_chk
  import tmo_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  wr_en,
  input logic [REG_ADDR_W-1:0] wr_addr,
  input logic                  clr_bit,
  input logic                  lock_cce,
  input logic                  lock_init,
  input logic                  bit_tick,
  input logic [NUM_QUEUES-1:0] q_empty,
  input logic                  cfg_en,
  input logic [MODE_W-1:0]     cfg_mode,
  input logic [CNT_W-1:0]      cfg_period,
  input logic [CNT_W-1:0]      cnt_o,
  input logic                  timeout_o
);
  logic qsel_empty;
  logic cont_reload;
  logic no_load;

  always_comb begin
    case (cfg_mode)
      2'd1:    qsel_empty = q_empty[0];
      2'd2:    qsel_empty = q_empty[1];
      2'd3:    qsel_empty = q_empty[2];
      default: qsel_empty = 1'b0;
    endcase
  end

  assign cont_reload = wr_en && (wr_addr == A_CNT) && (cfg_mode == 2'd0);
  assign no_load     = !cont_reload && !((cfg_mode != 2'd0) && qsel_empty);

  // R2
  a_r2_cfg_locked: assert property (@(posedge clk) disable iff (rst)
    !(lock_cce && lock_init) |=> $stable(cfg_en) && $stable(cfg_mode) && $stable(cfg_period));

  // R3
  a_r3_frozen: assert property (@(posedge clk) disable iff (rst)
    !cfg_en |=> $stable(cnt_o));

  // R5
  a_r5_step: assert property (@(posedge clk) disable iff (rst)
    cfg_en && bit_tick && (cnt_o != '0) && no_load |=> cnt_o == $past(cnt_o) - CNT_W'(1));

  // R5
  a_r5_idle: assert property (@(posedge clk) disable iff (rst)
    cfg_en && !bit_tick && no_load |=> $stable(cnt_o));

  // R6
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    cfg_en && (cfg_mode != 2'd0) && qsel_empty |=> cnt_o == $past(cfg_period));

  // R8
  a_r8_flag_set: assert property (@(posedge clk) disable iff (rst)
    cfg_en && bit_tick && (cnt_o == CNT_W'(1)) && no_load |=> timeout_o);

  // R9
  a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
    timeout_o && !(wr_en && (wr_addr == A_STAT) && clr_bit) |=> timeout_o);
endmodule

bind timeout_ctr timeout_ctr_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .clr_bit    (wr_data[0]),
  .lock_cce   (lock_cce),
  .lock_init  (lock_init),
  .bit_tick   (bit_tick),
  .q_empty    (q_empty),
  .cfg_en     (cfg_en),
  .cfg_mode   (cfg_mode),
  .cfg_period (cfg_period),
  .cnt_o      (cnt_o),
  .timeout_o  (timeout_o)
);

// File: tb/timeout_ctr_bench.sv
`timescale 1ns/1ps
module timeout_ctr_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        lock_cce = 1'b0;
  logic        lock_init = 1'b0;
  logic        bit_tick = 1'b0;
  logic [2:0]  q_empty = '0;
  logic [15:0] cnt_o;
  logic        timeout_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  timeout_ctr u_timeout_ctr (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .lock_cce(lock_cce), .lock_init(lock_init), .bit_tick(bit_tick),
    .q_empty(q_empty), .cnt_o(cnt_o), .timeout_o(timeout_o)
  );

  // behavioural reference model
  bit          m_valid = 0;
  bit          m_en;
  int          m_mode;
  int          m_per;
  int          m_cnt;
  bit          m_flag;
  logic [31:0] m_rd;

  always @(posedge clk) begin
    if (rst) begin
      m_valid = 1; m_en = 0; m_mode = 0; m_per = 16'hFFFF;
      m_cnt = 16'hFFFF; m_flag = 0; m_rd = 0;
    end else if (m_valid) begin
      bit loaded;
      bit hit_zero;
      if (rd_en) begin
        case (rd_addr)
          2'd0: m_rd = (32'(m_en) << 31) | (32'(m_mode) << 16) | 32'(m_per);
          2'd1: m_rd = 32'(m_cnt);
          2'd2: m_rd = 32'(m_flag);
          default: m_rd = 0;
        endcase
      end
      loaded = 0;
      hit_zero = 0;
      if (m_en) begin
        if (m_mode == 0) loaded = wr_en && wr_addr == 2'd1;
        else loaded = q_empty[m_mode - 1];
        if (loaded) m_cnt = m_per;
        else if (bit_tick && m_cnt > 0) begin
          m_cnt = m_cnt - 1;
          hit_zero = (m_cnt == 0);
        end
      end
      if (wr_en && wr_addr == 2'd2 && wr_data[0]) m_flag = 0;
      if (hit_zero) m_flag = 1;
      if (wr_en && wr_addr == 2'd0 && lock_cce && lock_init) begin
        m_en = wr_data[31];
        m_mode = int'(wr_data[17:16]);
        m_per = int'(wr_data[15:0]);
      end
    end
  end

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (m_valid && !rst) begin
      chk("R5 model counter", cnt_o, m_cnt);
      chk("R9 model flag", timeout_o, m_flag);
      chk("R10 model rd_data", rd_data, m_rd);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<=20000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic cyc(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    cyc();
    wr_en = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    rd_en = 1; rd_addr = a;
    cyc();
    rd_en = 0;
    d = rd_data;
  endtask

  task automatic tk(int n);
    repeat (n) begin
      bit_tick = 1;
      cyc();
      bit_tick = 0;
    end
  endtask

  initial begin
    logic [31:0] v;
    cyc(3);
    rst = 0;
    cyc();
    chk("R1 counter", cnt_o, 16'hFFFF);
    chk("R1 flag", timeout_o, 0);
    rd(2'd0, v); chk("R1 cfg read", v, 32'h0000FFFF);

    wr(2'd0, 32'h8000_0005);
    rd(2'd0, v); chk("R2 locked write ignored", v, 32'h0000FFFF);
    lock_cce = 1; wr(2'd0, 32'h8000_0005);
    rd(2'd0, v); chk("R2 one lock not enough", v, 32'h0000FFFF);
    lock_init = 1; wr(2'd0, 32'h8000_0005);
    rd(2'd0, v); chk("R2 unlocked write", v, 32'h8000_0005);

    wr(2'd1, 32'h0000_1234); chk("R4 reload", cnt_o, 5);
    cyc(3);                  chk("R5 no tick", cnt_o, 5);
    tk(2);                   chk("R5 two ticks", cnt_o, 3);
    tk(3);                   chk("R8 reached zero", cnt_o, 0);
    chk("R8 flag set", timeout_o, 1);
    tk(2);                   chk("R8 stays zero", cnt_o, 0);

    wr(2'd2, 32'h0);         chk("R9 bit0 zero keeps flag", timeout_o, 1);
    wr(2'd2, 32'h1);         chk("R9 clear", timeout_o, 0);
    rd(2'd2, v);             chk("R10 status read", v, 0);

    wr(2'd1, 32'h0);         chk("R4 re-arm", cnt_o, 5);
    tk(2);                   chk("R5 ticks", cnt_o, 3);
    wr(2'd0, 32'h0000_0005);
    tk(2);                   chk("R3 disabled tick", cnt_o, 3);
    wr(2'd1, 32'h0);         chk("R3 disabled reload", cnt_o, 3);
    rd(2'd1, v);             chk("R10 counter read", v, 3);

    q_empty = 3'b111;
    wr(2'd0, 32'h8002_0004); chk("R3 enable lands after edge", cnt_o, 3);
    cyc();                   chk("R6 rx0 empty preset", cnt_o, 4);
    tk(2);                   chk("R6 held while empty", cnt_o, 4);
    q_empty = 3'b101;
    tk(1);                   chk("R7 first element starts", cnt_o, 3);
    q_empty = 3'b000;
    tk(1);                   chk("R7 other queues ignored", cnt_o, 2);
    q_empty = 3'b101;
    tk(1);                   chk("R7 other queues ignored", cnt_o, 1);
    wr(2'd1, 32'h0);         chk("R7 counter write ignored", cnt_o, 1);
    q_empty = 3'b111;
    cyc();                   chk("R6 re-arm on empty", cnt_o, 4);

    wr(2'd0, 32'h8001_0007); chk("R6 old mode at write edge", cnt_o, 4);
    cyc();                   chk("R6 tx-event preset", cnt_o, 7);
    q_empty = 3'b110;
    tk(1);                   chk("R7 tx-event counts", cnt_o, 6);
    wr(2'd0, 32'h8003_0009); chk("R7 tx-event nonempty hold", cnt_o, 6);
    q_empty = 3'b111;
    cyc();                   chk("R6 rx1 preset", cnt_o, 9);
    q_empty = 3'b011;
    tk(1);                   chk("R7 rx1 counts", cnt_o, 8);

    wr(2'd0, 32'h8000_0001);
    wr(2'd1, 32'h0);         chk("R4 period one", cnt_o, 1);
    chk("R9 flag clear before", timeout_o, 0);
    bit_tick = 1; wr(2'd2, 32'h1); bit_tick = 0;
    chk("R8 expire", cnt_o, 0);
    chk("R9 set wins over clear", timeout_o, 1);
    rd(2'd0, v);             chk("R10 cfg read", v, 32'h8000_0001);
    rd(2'd3, v);             chk("R10 unused address", v, 0);
    cyc(2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule